// File: doc/BRIEF.md
# Serial Write Port for a Character-Display Controller

This block is the write side of an on-screen character display controller. A host sends 16-bit words over a three-wire synchronous serial link: an active-low select, a serial clock and a data line. The block samples all three lines in its own system clock domain. The first word of each selected transfer is taken as an address. Every later word in the same transfer is data, and it goes to that address and then to the following ones. Data for the lower 288 addresses is passed out as a one-cycle write to an external display RAM. Each RAM word holds the character code in bits 7:0, the foreground RGB in bits 10:8, a blink flag in bit 11 and the background RGB in bits 14:12. The cell at row r and column c lives at (r-1)*24 + (c-1). The next nine addresses land in on-chip 16-bit control registers, which are exposed as one flat vector.

An asynchronous active-low clear input zeroes all control registers at once. When it is released, the block walks every RAM address and writes 0x00FF to each one. During that walk the serial link is ignored. A host therefore waits at least one RAM depth of system clocks after the clear before it starts sending.

Top module: `osd_serial_wr`

## Requirements
- R1: While csN is low, the bit on sdi is captured at each rising edge of sck. Bits form 16-bit words, most significant bit first.
- R2: The first complete word after csN falls is an address. Each later complete word before csN rises is data.
- R3: A data word for address A, with A from 0 to 287, produces exactly one cycle of ramWe high, with ramAddr equal to A and ramData equal to the word.
- R4: A data word for address A, with A from 288 (0x120) to 296 (0x128), is stored in control register A-288. Register k appears on ctrlRegs[16k+15:16k]. No RAM write is produced.
- R5: A data word for an address above 296 produces no RAM write and leaves every control register unchanged.
- R6: After each data word the target address goes up by one. Consecutive data words in one transfer therefore fill consecutive addresses, and this continues from RAM address 287 into register 0.
- R7: If csN rises before 16 bits of a word have arrived, the partial word is dropped. The next transfer starts again with an address word.
- R8: While clrN is low, every control register reads 0, without waiting for a clock edge.
- R9: After clrN rises, the block writes 0x00FF to RAM addresses 0, 1, …, 287, in that order, one per clock. Serial traffic during this walk has no effect.
- R10: Rising edges of sck while csN is high shift in nothing and change no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all serial lines are oversampled on it |
| clrN | input | 1 | Asynchronous active-low clear |
| csN | input | 1 | Active-low transfer select |
| sck | input | 1 | Serial bit clock from the host |
| sdi | input | 1 | Serial data, most significant bit first |
| ramWe | output | 1 | One-cycle display RAM write strobe |
| ramAddr | output | 9 | Display RAM write address |
| ramData | output | 16 | Display RAM write data |
| ctrlRegs | output | 144 | Nine 16-bit control registers, register k at bits 16k+15:16k |

## Verification
The main sweep is a single transfer of one address followed by 298 data words with arithmetically generated values. It covers every RAM address, every register and the first ignored address in one pass. Any slip in the address increment, in the bit order or in the RAM/register boundary shows up as a wrong entry in the write log. Separate short transfers aimed at a single register test the address-then-data framing on its own. Stray clock edges with the select high, words cut short by the select, and out-of-range addresses tell apart a design that drops unwanted input from one that shifts it in. A clear in the middle of the run, with a transfer sent during the fill walk, tests both the fill order and that traffic is ignored while the walk runs.

// File: rtl/osd_serial_wr_pkg.sv
package osd_serial_wr_pkg;

  // Strobes passed from the control to the datapath each clock.
  typedef struct packed {
    logic shiftEn;   // accept one serial bit
    logic shiftBit;  // the bit to accept
    logic takeAddr;  // the completed word is an address
    logic takeData;  // the completed word is data
    logic fillWe;    // clear walk writes one RAM word this cycle
  } wrStrobes_t;

endpackage

// File: rtl/osd_serial_wr_ctrl.sv
module osd_serial_wr_ctrl
  import osd_serial_wr_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int RAM_DEPTH = 288,
  parameter int SYNC_LEN  = 2
) (
  input  logic                         clk,
  input  logic                         clrN,
  input  logic                         csN,
  input  logic                         sck,
  input  logic                         sdi,
  output wrStrobes_t                   st,
  output logic [$clog2(RAM_DEPTH)-1:0] fillAddr
);
  localparam int RAM_AW = $clog2(RAM_DEPTH);
  localparam int CNT_W  = $clog2(WORD_W);
  localparam logic [CNT_W-1:0]  LAST_BIT  = CNT_W'(WORD_W - 1);
  localparam logic [RAM_AW-1:0] LAST_FILL = RAM_AW'(RAM_DEPTH - 1);

  logic [SYNC_LEN:0]   sckSync;
  logic [SYNC_LEN-1:0] csSync;
  logic [SYNC_LEN-1:0] sdiSync;
  logic                csHigh;
  logic                sckRise;
  logic [CNT_W-1:0]    bitCnt;
  logic                haveAddr;
  logic                fillActive;
  logic [RAM_AW-1:0]   fillCnt;

  // Synchronizers: the serial lines are sampled in the clk domain.
  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN) begin
      sckSync <= '0;
      csSync  <= '1;
      sdiSync <= '0;
    end else begin
      sckSync <= {sckSync[SYNC_LEN-1:0], sck};
      csSync  <= {csSync[SYNC_LEN-2:0], csN};
      sdiSync <= {sdiSync[SYNC_LEN-2:0], sdi};
    end
  end

  assign csHigh  = csSync[SYNC_LEN-1];
  assign sckRise = sckSync[SYNC_LEN-1] & ~sckSync[SYNC_LEN];

  // Walk of the RAM after the clear is released.
  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN) begin
      fillActive <= 1'b1;
      fillCnt    <= '0;
    end else if (fillActive) begin
      if (fillCnt == LAST_FILL) begin
        fillActive <= 1'b0;
      end else begin
        fillCnt <= fillCnt + 1'b1;
      end
    end
  end

  // Bit counter and word framing.
  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN) begin
      bitCnt   <= '0;
      haveAddr <= 1'b0;
    end else if (fillActive || csHigh) begin
      bitCnt   <= '0;
      haveAddr <= 1'b0;
    end else if (sckRise) begin
      if (bitCnt == LAST_BIT) begin
        bitCnt   <= '0;
        haveAddr <= 1'b1;
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  always_comb begin
    st.shiftEn  = !fillActive && !csHigh && sckRise;
    st.shiftBit = sdiSync[SYNC_LEN-1];
    st.takeAddr = st.shiftEn && (bitCnt == LAST_BIT) && !haveAddr;
    st.takeData = st.shiftEn && (bitCnt == LAST_BIT) && haveAddr;
    st.fillWe   = fillActive;
  end

  assign fillAddr = fillCnt;

  // R7: with the select high, the next cycle starts a word from bit zero.
  a_r7_cs_drops_partial: assert property (@(posedge clk) disable iff (!clrN)
    csHigh |=> (bitCnt == '0));

  // R9: the walk advances by exactly one address per clock until it ends.
  a_r9_fill_steps: assert property (@(posedge clk) disable iff (!clrN)
    (fillActive && fillCnt != LAST_FILL) |=> (fillCnt == $past(fillCnt) + 1'b1));

endmodule

// File: rtl/osd_serial_wr_dp.sv
module osd_serial_wr_dp
  import osd_serial_wr_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int RAM_DEPTH = 288,
  parameter int REG_COUNT = 9,
  parameter logic [WORD_W-1:0] FILL_WORD = 16'h00FF
) (
  input  logic                          clk,
  input  logic                          clrN,
  input  wrStrobes_t                    st,
  input  logic [$clog2(RAM_DEPTH)-1:0]  fillAddr,
  output logic                          ramWe,
  output logic [$clog2(RAM_DEPTH)-1:0]  ramAddr,
  output logic [WORD_W-1:0]             ramData,
  output logic [REG_COUNT*WORD_W-1:0]   ctrlRegs
);
  localparam int RAM_AW = $clog2(RAM_DEPTH);
  localparam logic [WORD_W-1:0] RAM_LIMIT = WORD_W'(RAM_DEPTH);
  localparam logic [WORD_W-1:0] REG_LAST  = WORD_W'(RAM_DEPTH + REG_COUNT - 1);

  logic [WORD_W-1:0] shiftReg;
  logic [WORD_W-1:0] nextWord;
  logic [WORD_W-1:0] addrReg;
  logic              ramHit;

  assign nextWord = {shiftReg[WORD_W-2:0], st.shiftBit};
  assign ramHit   = addrReg < RAM_LIMIT;

  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN) begin
      shiftReg <= '0;
      addrReg  <= '0;
    end else begin
      if (st.shiftEn) shiftReg <= nextWord;
      if (st.takeAddr) addrReg <= nextWord;
      else if (st.takeData) addrReg <= addrReg + 1'b1;
    end
  end

  // RAM write port: the clear walk and serial data share it.
  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN) begin
      ramWe   <= 1'b0;
      ramAddr <= '0;
      ramData <= '0;
    end else if (st.fillWe) begin
      ramWe   <= 1'b1;
      ramAddr <= fillAddr;
      ramData <= FILL_WORD;
    end else if (st.takeData && ramHit) begin
      ramWe   <= 1'b1;
      ramAddr <= addrReg[RAM_AW-1:0];
      ramData <= nextWord;
    end else begin
      ramWe <= 1'b0;
    end
  end

  // Control registers, one decoded slot each.
  for (genvar i = 0; i < REG_COUNT; i++) begin : g_reg
    localparam logic [WORD_W-1:0] SLOT_ADDR = WORD_W'(RAM_DEPTH + i);
    logic [WORD_W-1:0] value;
    always_ff @(posedge clk or negedge clrN) begin
      if (!clrN) value <= '0;
      else if (st.takeData && addrReg == SLOT_ADDR) value <= nextWord;
    end
    assign ctrlRegs[i*WORD_W +: WORD_W] = value;
  end

  // R3: a RAM write never points past the last display cell.
  a_r3_ram_addr_range: assert property (@(posedge clk) disable iff (!clrN)
    ramWe |-> (ramAddr < RAM_AW'(RAM_DEPTH)));

  // R4: registers only change on a completed data word.
  a_r4_regs_quiet: assert property (@(posedge clk) disable iff (!clrN)
    !st.takeData |=> $stable(ctrlRegs));

  // R5: data for an address beyond the register block writes no RAM.
  a_r5_high_addr_no_write: assert property (@(posedge clk) disable iff (!clrN)
    (st.takeData && !st.fillWe && addrReg > REG_LAST) |=> !ramWe);

endmodule

// File: rtl/osd_serial_wr.sv
module osd_serial_wr
  import osd_serial_wr_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int RAM_DEPTH = 288,
  parameter int REG_COUNT = 9,
  parameter int SYNC_LEN  = 2
) (
  input  logic                         clk,
  input  logic                         clrN,
  input  logic                         csN,
  input  logic                         sck,
  input  logic                         sdi,
  output logic                         ramWe,
  output logic [$clog2(RAM_DEPTH)-1:0] ramAddr,
  output logic [WORD_W-1:0]            ramData,
  output logic [REG_COUNT*WORD_W-1:0]  ctrlRegs
);
  localparam int RAM_AW = $clog2(RAM_DEPTH);

  wrStrobes_t        strobes;
  logic [RAM_AW-1:0] fillAddr;

  osd_serial_wr_ctrl #(
    .WORD_W(WORD_W), .RAM_DEPTH(RAM_DEPTH), .SYNC_LEN(SYNC_LEN)
  ) ctrl_i (
    .clk(clk), .clrN(clrN), .csN(csN), .sck(sck), .sdi(sdi),
    .st(strobes), .fillAddr(fillAddr)
  );

  osd_serial_wr_dp #(
    .WORD_W(WORD_W), .RAM_DEPTH(RAM_DEPTH), .REG_COUNT(REG_COUNT)
  ) dp_i (
    .clk(clk), .clrN(clrN), .st(strobes), .fillAddr(fillAddr),
    .ramWe(ramWe), .ramAddr(ramAddr), .ramData(ramData), .ctrlRegs(ctrlRegs)
  );

endmodule

// File: tb/osd_serial_wr_tb_top.sv
module osd_serial_wr_tb_top;
  logic clk = 1'b0;
  logic clrN = 1'b0;
  logic csN = 1'b1;
  logic sck = 1'b0;
  logic sdi = 1'b0;
  logic         ramWe;
  logic [8:0]   ramAddr;
  logic [15:0]  ramData;
  logic [143:0] ctrlRegs;

  int nTests = 0;
  int nFail  = 0;
  int logN   = 0;
  logic [8:0]  logAddr [0:1023];
  logic [15:0] logData [0:1023];

  always #10 clk = ~clk;

  osd_serial_wr dut_i (
    .clk(clk), .clrN(clrN), .csN(csN), .sck(sck), .sdi(sdi),
    .ramWe(ramWe), .ramAddr(ramAddr), .ramData(ramData), .ctrlRegs(ctrlRegs)
  );

  always @(negedge clk) begin
    if (ramWe) begin
      if (logN < 1024) begin
        logAddr[logN] = ramAddr;
        logData[logN] = ramData;
      end
      logN = logN + 1;
    end
  end

  function automatic logic [15:0] pat(input int i);
    return 16'((i * 40503) + 16'h1357);
  endfunction

  function automatic logic [15:0] regVal(input int k);
    return ctrlRegs[k*16 +: 16];
  endfunction

  task automatic check(input logic ok, input string req, input longint act, input longint exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sendBit(input logic b);
    @(negedge clk); sdi = b;
    repeat (2) @(negedge clk); sck = 1'b1;
    repeat (3) @(negedge clk); sck = 1'b0;
  endtask

  task automatic sendWord(input logic [15:0] w);
    for (int b = 15; b >= 0; b--) sendBit(w[b]);
  endtask

  task automatic csLow();
    @(negedge clk); csN = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic csHighT();
    repeat (3) @(negedge clk); csN = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic frame1(input logic [15:0] a, input logic [15:0] d);
    csLow(); sendWord(a); sendWord(d); csHighT();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    int base;
    logic [143:0] snap;
    int bad;

    // R8: registers zero while clear is held.
    repeat (3) @(negedge clk);
    check(ctrlRegs == '0, "R8 reset regs", longint'(ctrlRegs[63:0]), 0);
    check(ramWe == 1'b0, "R8 no write during clear", ramWe, 0);
    base = logN;
    clrN = 1'b1;
    repeat (320) @(negedge clk);
    // R9: ascending fill of 0x00FF.
    check(logN - base == 288, "R9 fill count", logN - base, 288);
    bad = 0;
    for (int i = 0; i < 288; i++)
      if (logAddr[base+i] != 9'(i) || logData[base+i] != 16'h00FF) bad++;
    check(bad == 0, "R9 fill order/data", bad, 0);

    // R1 R2 R3 R4 R5 R6: one long transfer across RAM, registers and beyond.
    base = logN;
    csLow();
    sendWord(16'h0000);
    for (int i = 0; i < 298; i++) sendWord(pat(i));
    csHighT();
    check(logN - base == 288, "R3 RAM write count", logN - base, 288);
    bad = 0;
    for (int i = 0; i < 288; i++)
      if (logAddr[base+i] != 9'(i) || logData[base+i] != pat(i)) bad++;
    check(bad == 0, "R6 sequential RAM contents", bad, 0);
    for (int k = 0; k < 9; k++)
      check(regVal(k) == pat(288 + k), "R4 register via increment", regVal(k), pat(288 + k));

    // R2: separate short transfers, each starting with an address.
    frame1(16'h0125, 16'hA5C3);
    check(regVal(5) == 16'hA5C3, "R2 single register write", regVal(5), 16'hA5C3);
    base = logN;
    frame1(16'h011F, 16'h7E81);
    check(logN - base == 1 && logAddr[base] == 9'h11F && logData[base] == 16'h7E81,
          "R3 last RAM cell", logData[base], 16'h7E81);

    // R6: increment crosses from RAM into register 0.
    base = logN;
    csLow(); sendWord(16'h011F); sendWord(16'h1111); sendWord(16'h2222); csHighT();
    check(logN - base == 1, "R6 boundary RAM writes", logN - base, 1);
    check(regVal(0) == 16'h2222, "R6 boundary into reg0", regVal(0), 16'h2222);

    // R5: addresses above the register block.
    snap = ctrlRegs; base = logN;
    frame1(16'h0129, 16'hDEAD);
    frame1(16'hFFF0, 16'hBEEF);
    check(logN == base, "R5 no RAM write", logN - base, 0);
    check(ctrlRegs == snap, "R5 regs unchanged", longint'(ctrlRegs[63:0]), longint'(snap[63:0]));

    // R10: sck edges with select high.
    snap = ctrlRegs; base = logN;
    for (int i = 0; i < 20; i++) sendBit(1'b1);
    repeat (6) @(negedge clk);
    check(logN == base && ctrlRegs == snap, "R10 idle edges ignored", logN - base, 0);
    frame1(16'h0128, 16'h3C3C);
    check(regVal(8) == 16'h3C3C, "R10 framing intact", regVal(8), 16'h3C3C);

    // R7: partial address word dropped.
    csLow(); for (int i = 0; i < 7; i++) sendBit(1'b1); csHighT();
    frame1(16'h0122, 16'h0F0F);
    check(regVal(2) == 16'h0F0F, "R7 partial address dropped", regVal(2), 16'h0F0F);
    // R7: partial data word dropped, earlier data kept.
    snap = ctrlRegs;
    csLow(); sendWord(16'h0123); sendWord(16'h4242);
    for (int i = 0; i < 5; i++) sendBit(1'b0);
    csHighT();
    check(regVal(3) == 16'h4242, "R7 complete data kept", regVal(3), 16'h4242);
    check(regVal(4) == snap[79:64], "R7 partial data dropped", regVal(4), snap[79:64]);

    // R8 R9: clear mid-run, with traffic during the walk.
    @(negedge clk); clrN = 1'b0;
    #1;
    check(ctrlRegs == '0, "R8 async clear", longint'(ctrlRegs[63:0]), 0);
    repeat (3) @(negedge clk);
    base = logN;
    clrN = 1'b1;
    frame1(16'h0121, 16'hBEEF);
    repeat (150) @(negedge clk);
    check(logN - base == 288, "R9 refill count", logN - base, 288);
    check(regVal(1) == 16'h0000, "R9 traffic during walk ignored", regVal(1), 0);
    frame1(16'h0121, 16'h5A5A);
    check(regVal(1) == 16'h5A5A, "R1 write after walk", regVal(1), 16'h5A5A);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule